// File: doc/BRIEF.md
# State-Banked Register File Controller

This block keeps a separate register bank for each processor operating state. One bank serves the application (task) state. Each of the four executive states has its own bank, and each executive state belongs to one interrupt class. A 3-bit state field picks the bank that is active. The two read ports and the single write port always reach that bank and no other. When the state changes, the active bank changes on the same clock edge, so software never issues an instruction to swap banks.

Interrupt logic moves the block into an executive state with an entry request. Before it changes state, the block pushes the interrupted state onto a small stack. A return command pops that state back. The interrupted state's bank was never written while it was inactive, so its contents come back exactly as they were left. The status field can also be loaded directly, and a code outside the legal range is dropped.

The decoder marks each issued instruction that is privileged. If such an instruction arrives while the block is in task state, the block raises a fault pulse and suppresses the instruction's register write.

Top module: `banked_regfile_ctrl`

## Requirements
- R1: After reset the state is task (code 0), every register of every bank reads zero, and `priv_fault` and `stack_err` are low.
- R2: `rd_data_a` and `rd_data_b` combinationally return the registers named by `rd_addr_a` and `rd_addr_b` in the bank of the current state. The two ports are independent.
- R3: A write (`wr_en`, `wr_addr`, `wr_data`) updates only the addressed register of the bank of the current state. All other banks keep their contents.
- R4: `enter_req` with class c (0 to 3) pushes the current state and sets the state to c+1 at the next edge.
- R5: `ret_req` pops the most recently pushed state and makes it current at the next edge. The restored bank holds exactly the values it held before the entry.
- R6: `ret_req` with an empty stack leaves the state unchanged and pulses `stack_err` high for one cycle in the following cycle.
- R7: `enter_req` while 4 states are already stacked is dropped: the state and the stack are unchanged, and `stack_err` pulses for one cycle.
- R8: `stat_we` loads `stat_val` into the state when the value is 0 to 4. Values 5 to 7 are ignored. A load never touches the stack.
- R9: When several commands arrive in one cycle, `ret_req` wins over `enter_req`, and `enter_req` wins over `stat_we`.
- R10: An instruction with `insn_valid` and `insn_priv` high, issued in task state, pulses `priv_fault` in the next cycle and blocks its write. In any executive state it raises no fault and its write proceeds.
- R11: A write issued in the same cycle as a state change lands in the bank of the state that was active before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction is issued this cycle |
| insn_priv | input | 1 | The issued instruction is privileged |
| rd_addr_a | input | 3 | Read port A register index |
| rd_data_a | output | 32 | Read port A data from the active bank |
| rd_addr_b | input | 3 | Read port B register index |
| rd_data_b | output | 32 | Read port B data from the active bank |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Write register index |
| wr_data | input | 32 | Write data |
| enter_req | input | 1 | Interrupt entry into an executive state |
| enter_class | input | 2 | Interrupt class of the entry (0 to 3) |
| ret_req | input | 1 | Return to the previously stacked state |
| stat_we | input | 1 | Direct load of the state field |
| stat_val | input | 3 | State code to load (0 task, 1 to 4 executive) |
| cur_state | output | 3 | Current state code |
| priv_fault | output | 1 | One-cycle privilege fault pulse |
| stack_err | output | 1 | One-cycle stack underflow/overflow pulse |

## Verification
The assertions check four properties on every cycle:
- The state code stays legal.
- Returns on an empty stack, and entries on a full stack, produce an error pulse.
- An entry lands in the state of its class, and an illegal load leaves the state alone.
- A fault follows only a privileged instruction issued in task state, and a blocked write leaves the addressed register untouched.

Some behaviour can only be shown by the bench's scenarios: that a bank comes back intact after nested entries and returns, that the 4-deep stack unwinds in order, that a write issued with a state change lands in the old bank, and how commands that arrive together are prioritised. The bench compares these against a behavioural model on every cycle.

// File: rtl/brf_pkg.sv
package brf_pkg;

  // Command chosen for the state controller in one cycle, after priority.
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOAD   = 2'd1,
    OP_ENTER  = 2'd2,
    OP_RETURN = 2'd3
  } st_op_e;

  // State code 0 always means the task (application) state.
  localparam int unsigned TASK_CODE = 0;

endpackage

// File: rtl/brf_state_ctrl.sv
module brf_state_ctrl
  import brf_pkg::*;
#(
  parameter int BANKS = 5,
  parameter int DEPTH = 4,
  parameter int SW    = 3,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_req,
  input  logic          enter_req,
  input  logic [CW-1:0] enter_class,
  input  logic          stat_we,
  input  logic [SW-1:0] stat_val,
  output logic [SW-1:0] cur_state,
  output logic          stack_err
);

  localparam int DW = $clog2(DEPTH + 1);

  st_op_e        op;
  logic [SW-1:0] state_q, state_d;
  logic [DW-1:0] depth_q, depth_d;
  logic          err_q, err_d;
  logic          push;
  logic [SW-1:0] stk_q [DEPTH];
  logic          empty, full;

  assign empty = (depth_q == '0);
  assign full  = (depth_q == DW'(DEPTH));

  // Command priority: return, then entry, then direct load.
  always_comb begin
    if (ret_req)        op = OP_RETURN;
    else if (enter_req) op = OP_ENTER;
    else if (stat_we)   op = OP_LOAD;
    else                op = OP_NONE;
  end

  always_comb begin
    state_d = state_q;
    depth_d = depth_q;
    err_d   = 1'b0;
    push    = 1'b0;
    case (op)
      OP_RETURN: begin
        if (empty) begin
          err_d = 1'b1;
        end else begin
          state_d = stk_q[depth_q - DW'(1)];
          depth_d = depth_q - DW'(1);
        end
      end
      OP_ENTER: begin
        if (full) begin
          err_d = 1'b1;
        end else begin
          push    = 1'b1;
          depth_d = depth_q + DW'(1);
          state_d = SW'(enter_class) + SW'(1);
        end
      end
      OP_LOAD: begin
        if (32'(stat_val) < BANKS) state_d = stat_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW'(TASK_CODE);
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      depth_q <= depth_d;
      err_q   <= err_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stk_q[g] <= '0;
      end else if (push && (depth_q == DW'(g))) begin
        stk_q[g] <= state_q;
      end
    end
  end

  assign cur_state = state_q;
  assign stack_err = err_q;

  // R8
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(state_q) < BANKS);

  // R8
  illegal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_req && !enter_req && stat_we && (32'(stat_val) >= BANKS))
      |=> $stable(state_q) && !stack_err);

  // R6
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && empty) |=> (stack_err && $stable(state_q)));

  // R7
  full_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_req && enter_req && full) |=> (stack_err && $stable(state_q)));

  // R4
  enter_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_req && enter_req && !full) |=> (state_q == SW'($past(enter_class)) + SW'(1)));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(depth_q) <= DEPTH);

endmodule

// File: rtl/brf_bank_array.sv
module brf_bank_array #(
  parameter int BANKS  = 5,
  parameter int REGS   = 8,
  parameter int DATA_W = 32,
  parameter int AW     = 3,
  parameter int SW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     sel,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem_q [BANKS][REGS];

  // One enabled register per bank and index. Only the selected bank takes the write.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar r = 0; r < REGS; r++) begin : g_reg
      logic wen;
      assign wen = we && (sel == SW'(b)) && (waddr == AW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[b][r] <= '0;
        end else if (wen) begin
          mem_q[b][r] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (sel == SW'(b)) begin
        rdata_a = mem_q[b][raddr_a];
        rdata_b = mem_q[b][raddr_b];
      end
    end
  end

endmodule

// File: rtl/banked_regfile_ctrl.sv
module banked_regfile_ctrl
  import brf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REGS        = 8,
  parameter int EXEC_STATES = 4,
  parameter int STACK_DEPTH = 4,
  localparam int BANKS      = EXEC_STATES + 1,
  localparam int AW         = $clog2(REGS),
  localparam int SW         = $clog2(BANKS),
  localparam int CW         = $clog2(EXEC_STATES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic              insn_priv,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              enter_req,
  input  logic [CW-1:0]     enter_class,
  input  logic              ret_req,
  input  logic              stat_we,
  input  logic [SW-1:0]     stat_val,
  output logic [SW-1:0]     cur_state,
  output logic              priv_fault,
  output logic              stack_err
);

  logic fault_now;
  logic wr_gate;
  logic fault_q;

  brf_state_ctrl #(
    .BANKS (BANKS),
    .DEPTH (STACK_DEPTH),
    .SW    (SW),
    .CW    (CW)
  ) i_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_req     (ret_req),
    .enter_req   (enter_req),
    .enter_class (enter_class),
    .stat_we     (stat_we),
    .stat_val    (stat_val),
    .cur_state   (cur_state),
    .stack_err   (stack_err)
  );

  // A privileged instruction in task state faults and loses its write.
  assign fault_now = insn_valid && insn_priv && (cur_state == SW'(TASK_CODE));
  assign wr_gate   = wr_en && !fault_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_now;
  end

  assign priv_fault = fault_q;

  // The bank select is the pre-edge state, so a write issued with a state change
  // lands in the old bank.
  brf_bank_array #(
    .BANKS  (BANKS),
    .REGS   (REGS),
    .DATA_W (DATA_W),
    .AW     (AW),
    .SW     (SW)
  ) i_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (cur_state),
    .we      (wr_gate),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .raddr_a (rd_addr_a),
    .raddr_b (rd_addr_b),
    .rdata_a (rd_data_a),
    .rdata_b (rd_data_b)
  );

  // R10
  exec_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_priv && (cur_state != SW'(TASK_CODE))) |=> !priv_fault);

  // R10
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_valid || !insn_priv) |=> !priv_fault);

  // R10
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_priv && wr_en && (cur_state == SW'(TASK_CODE)) &&
     !ret_req && !enter_req && !stat_we && (rd_addr_a == wr_addr))
      |=> (!$stable(rd_addr_a) || $stable(rd_data_a)));

endmodule

// File: tb/test_banked_regfile_ctrl.sv
`timescale 1ns/1ps
module test_banked_regfile_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 0, insn_priv = 0;
  logic [2:0]  rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0, stat_val = 0;
  logic [31:0] wr_data = 0;
  logic        wr_en = 0, enter_req = 0, ret_req = 0, stat_we = 0;
  logic [1:0]  enter_class = 0;
  logic [31:0] rd_data_a, rd_data_b;
  logic [2:0]  cur_state;
  logic        priv_fault, stack_err;

  banked_regfile_ctrl i_banked_regfile_ctrl (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_priv(insn_priv),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enter_req(enter_req), .enter_class(enter_class), .ret_req(ret_req),
    .stat_we(stat_we), .stat_val(stat_val),
    .cur_state(cur_state), .priv_fault(priv_fault), .stack_err(stack_err)
  );

  always #2.5 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  bit    started = 0;
  string cur_req = "R1";

  // Reference model
  logic [31:0] m_mem [5][8];
  int          m_state = 0;
  int          m_stk[$];
  bit          m_fault = 0, m_err = 0;

  initial begin
    for (int b = 0; b < 5; b++)
      for (int r = 0; r < 8; r++) m_mem[b][r] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 5; b++)
        for (int r = 0; r < 8; r++) m_mem[b][r] = '0;
      m_state = 0;
      m_stk.delete();
      m_fault = 0;
      m_err = 0;
    end else begin
      bit f;
      bit e;
      f = insn_valid && insn_priv && (m_state == 0);
      e = 0;
      if (wr_en && !f) m_mem[m_state][wr_addr] = wr_data;
      if (ret_req) begin
        if (m_stk.size() == 0) e = 1;
        else m_state = m_stk.pop_back();
      end else if (enter_req) begin
        if (m_stk.size() == 4) e = 1;
        else begin
          m_stk.push_back(m_state);
          m_state = int'(enter_class) + 1;
        end
      end else if (stat_we && stat_val <= 3'd4) begin
        m_state = int'(stat_val);
      end
      m_fault = f;
      m_err = e;
    end
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(cur_state == 3'(m_state), "state", cur_state, m_state);
      chk(rd_data_a == m_mem[m_state][rd_addr_a], "rd_a", rd_data_a, m_mem[m_state][rd_addr_a]);
      chk(rd_data_b == m_mem[m_state][rd_addr_b], "rd_b", rd_data_b, m_mem[m_state][rd_addr_b]);
      chk(priv_fault == m_fault, "priv_fault", priv_fault, m_fault);
      chk(stack_err == m_err, "stack_err", stack_err, m_err);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    insn_valid = 0; insn_priv = 0; wr_en = 0; enter_req = 0;
    ret_req = 0; stat_we = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    clr();
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    rd_addr_a = 3'(a); rd_addr_b = 3'(7 - a);
    step();
  endtask

  task automatic sweep();
    clr();
    for (int i = 0; i < 8; i++) begin
      rd_addr_a = 3'(i); rd_addr_b = 3'(7 - i);
      step();
    end
  endtask

  task automatic enter(int c);
    clr(); enter_req = 1; enter_class = 2'(c); step();
  endtask

  task automatic ret();
    clr(); ret_req = 1; step();
  endtask

  task automatic load(int v);
    clr(); stat_we = 1; stat_val = 3'(v); step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    repeat (2) @(posedge clk);
    #1;
    started = 1;
    step();
    rst_n = 1;
    sweep();

    cur_req = "R2";
    for (int i = 0; i < 8; i++) wr(i, 32'h1000_0000 + i * 32'h11);
    sweep();

    cur_req = "R8";
    load(1);
    cur_req = "R3";
    for (int i = 0; i < 8; i++) wr(i, 32'hE000_0000 ^ (i * 32'h0101));
    sweep();
    cur_req = "R8";
    load(5); load(6); load(7);
    sweep();
    load(0);
    sweep();

    cur_req = "R4";
    enter(2);
    wr(3, 32'hC0DE_0002);
    enter(0);
    wr(3, 32'hC0DE_0000);
    enter(3);
    wr(5, 32'hC0DE_0003);
    enter(1);
    wr(1, 32'hC0DE_0001);
    sweep();
    cur_req = "R7";
    enter(2);
    sweep();
    cur_req = "R5";
    for (int k = 0; k < 4; k++) begin
      ret();
      sweep();
    end
    cur_req = "R6";
    ret();
    ret();
    sweep();

    cur_req = "R11";
    clr();
    enter_req = 1; enter_class = 2'd3;
    wr_en = 1; wr_addr = 3'd6; wr_data = 32'hAAAA_5555;
    step();
    sweep();
    clr();
    ret_req = 1; wr_en = 1; wr_addr = 3'd2; wr_data = 32'h5A5A_0011;
    step();
    sweep();

    cur_req = "R9";
    load(2);
    clr();
    enter_req = 1; enter_class = 2'd0; stat_we = 1; stat_val = 3'd4;
    step();
    clr();
    ret_req = 1; enter_req = 1; enter_class = 2'd2; stat_we = 1; stat_val = 3'd3;
    step();
    sweep();
    load(0);

    cur_req = "R10";
    clr();
    insn_valid = 1; insn_priv = 1; wr_en = 1; wr_addr = 3'd4; wr_data = 32'hDEAD_BEEF;
    rd_addr_a = 3'd4;
    step();
    clr();
    insn_valid = 1; insn_priv = 1;
    step();
    clr();
    insn_valid = 1; insn_priv = 0; wr_en = 1; wr_addr = 3'd4; wr_data = 32'h0000_4444;
    step();
    load(4);
    clr();
    insn_valid = 1; insn_priv = 1; wr_en = 1; wr_addr = 3'd4; wr_data = 32'hFEED_0004;
    step();
    sweep();
    load(0);

    cur_req = "R3";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      clr();
      insn_valid = r[0]; insn_priv = r[1] & r[2];
      wr_en = r[3]; wr_addr = r[6:4]; wr_data = $urandom;
      rd_addr_a = r[9:7]; rd_addr_b = r[12:10];
      enter_req = (r[15:13] == 3'd0); enter_class = r[17:16];
      ret_req = (r[20:18] == 3'd0);
      stat_we = (r[22:21] == 2'd0); stat_val = r[25:23];
      step();
    end
    clr();
    step();
    finish_run();
  end

endmodule